// File: doc/BRIEF.md
# Command-Processor ALU with Carry Register

This block is the arithmetic and logic unit of a small command-processor core. It takes an opcode and two operands and returns a 32-bit result. The second operand comes either from a register value or from an immediate. The datapath is combinational, so the result follows the inputs within the same cycle. The only state is a carry register. It is updated only on a cycle where the execute strobe is high and the opcode is one of the two carry-producing operations.

The carry is used to build wider arithmetic from 32-bit steps. A low-word add leaves a carry of 0 or 1, and a later add-high folds it in. A low-word subtract leaves 0, or all ones when it borrowed, and a later subtract-high adds that in, which takes off one. The instruction set also includes a compare that returns fixed code values rather than flags, a most-significant-bit finder, and a single-bit write whose position and new value are both packed into operand B.

Top module: `cp_alu`

## Requirements
- R1: A synchronous active-low reset clears the carry register to zero, so an add-with-carry (opcode 1) right after reset returns A+B exactly.
- R2: Opcode 0 returns the low 32 bits of A+B. When exec is high, bit 32 of the sum is written to the carry register on the clock edge.
- R3: Opcode 1 returns A+B+carry (mod 2^32) and never changes the carry register, even with exec high.
- R4: Opcode 2 returns A−B (mod 2^32). When exec is high it loads the carry register with all ones if A<B (unsigned) and with zero otherwise. Opcode 3 returns A−B+carry (mod 2^32) and does not change the carry register.
- R5: The logic opcodes return the following: AND (opcode 4) gives A&B, OR (5) gives A|B, XOR (6) gives A^B, NOT (7) gives ~A, and bit clear (8) gives A&~B.
- R6: The shift opcodes use B[4:0] as the amount. Shift left is opcode 9. Logical right shift is opcode 10 and fills with zeros. Arithmetic right shift is opcode 11 and copies A[31] into the vacated bits.
- R7: Opcode 12 rotates A left by B[4:0] within 32 bits. When B[31] is set, the amount is read as negative, so a result of rotating right by (−B)[4:0] is produced.
- R8: Opcode 13 returns A[7:0]×B[7:0] as a 16-bit product, zero-extended to 32 bits.
- R9: Opcode 14 returns the unsigned minimum of A and B, and opcode 15 returns the unsigned maximum.
- R10: Opcode 16 compares A and B unsigned. It returns 0x00 if A>B, 0x2B if A==B, and 0x1E if A<B.
- R11: Opcode 17 returns the index of the highest set bit of B, or 0 when B is zero.
- R12: Opcode 18 takes a bit position from B[5:1] and writes B[0] into that bit of A. Every other bit of A passes through unchanged.
- R13: With exec low, or with any opcode other than 0 and 2, the carry register keeps its value.
- R14: When use_imm is high, operand B is taken from imm instead of opb. Opcodes 19 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute strobe, qualifies carry updates |
| opcode_i | input | 5 | Operation select |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B from register |
| imm_i | input | 32 | Immediate operand B |
| use_imm_i | input | 1 | Select imm_i as operand B |
| result_o | output | 32 | Operation result |

## Verification
A vector table drives every stateless opcode with operands chosen to separate the variants that a wrong implementation would confuse:
- values with the top bit set, to tell unsigned from signed comparison and logical from arithmetic shift;
- shift amounts above 31, to show that only the low five bits count;
- negative rotate amounts, to tell left rotation from right;
- low bytes of 0xFF, to confirm the full 16-bit product;
- equal, greater and lesser operands, which reach the three compare codes.

Directed sequences then exercise the carry register across cycles: overflowing and non-overflowing adds, borrowing and non-borrowing subtracts, cycles with the strobe low, carry-neutral opcodes issued with the strobe high, and a reset taken while the carry is set. The carry is observed only through later add-high and subtract-high results.

// File: rtl/cp_alu_pkg.sv
// Package: opcode encoding and shared widths for the command-processor ALU.
// Assumes opcodes above OP_SETB are unassigned and yield a zero result.
package cp_alu_pkg;
    localparam int OPCODE_W = 5;

    typedef enum logic [OPCODE_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBC = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOT  = 5'd7,
        OP_BIC  = 5'd8,
        OP_SHL  = 5'd9,
        OP_SHRU = 5'd10,
        OP_SHRS = 5'd11,
        OP_ROTL = 5'd12,
        OP_MUL8 = 5'd13,
        OP_MIN  = 5'd14,
        OP_MAX  = 5'd15,
        OP_CMP  = 5'd16,
        OP_MSB  = 5'd17,
        OP_SETB = 5'd18
    } alu_op_e;

    // Fixed compare codes
    localparam logic [7:0] CMP_GT = 8'h00;
    localparam logic [7:0] CMP_EQ = 8'h2B;
    localparam logic [7:0] CMP_LT = 8'h1E;
endpackage

// File: rtl/cp_alu_arith.sv
// Module: add/subtract unit with carry production and consumption.
// Produces the four arithmetic results and the carry value that a low-word
// add or subtract would store. Assumes the caller decides when to store it.
module cp_alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] add_o,
    output logic [W-1:0] addc_o,
    output logic [W-1:0] sub_o,
    output logic [W-1:0] subc_o,
    output logic [W-1:0] add_carry_o,
    output logic [W-1:0] sub_carry_o
);
    logic [W:0] sum_w;
    logic [W:0] diff_w;

    // Wide sum and difference exposing the carry-out and borrow bits
    always_comb begin
        sum_w  = {1'b0, a_i} + {1'b0, b_i};
        diff_w = {1'b0, a_i} - {1'b0, b_i};
    end

    // Low-word results and the carry values each would store
    always_comb begin
        add_o       = sum_w[W-1:0];
        sub_o       = diff_w[W-1:0];
        add_carry_o = {{(W-1){1'b0}}, sum_w[W]};
        sub_carry_o = {W{diff_w[W]}};
    end

    // High-word results that fold in the stored carry
    always_comb begin
        addc_o = a_i + b_i + carry_i;
        subc_o = a_i - b_i + carry_i;
    end
endmodule

// File: rtl/cp_alu_bitops.sv
// Module: logic, shift and rotate unit.
// Amounts use the low log2(W) bits of B. Assumes W is a power of two, so a
// negative rotate amount taken modulo W is the same as a right rotation.
module cp_alu_bitops #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] not_o,
    output logic [W-1:0] bic_o,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shru_o,
    output logic [W-1:0] shrs_o,
    output logic [W-1:0] rotl_o
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt;

    // Bitwise logic results
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
        not_o = ~a_i;
        bic_o = a_i & ~b_i;
    end

    // Shifts by the truncated amount
    always_comb begin
        amt    = b_i[SHW-1:0];
        shl_o  = a_i << amt;
        shru_o = a_i >> amt;
        shrs_o = $signed(a_i) >>> amt;
    end

    // Rotation: each output bit picks its source index modulo W
    always_comb begin
        logic [SHW-1:0] src;
        rotl_o = '0;
        for (int i = 0; i < W; i++) begin
            src       = SHW'(i) - amt;
            rotl_o[i] = a_i[src];
        end
    end
endmodule

// File: rtl/cp_alu_misc.sv
// Module: narrow multiply, unsigned min/max, code compare, highest-set-bit
// index and packed single-bit write. Purely combinational.
module cp_alu_misc #(
    parameter int W     = 32,
    parameter int MUL_W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mul_o,
    output logic [W-1:0] min_o,
    output logic [W-1:0] max_o,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] msb_o,
    output logic [W-1:0] setb_o
);
    import cp_alu_pkg::*;

    localparam int SHW  = $clog2(W);
    localparam int PROD = 2 * MUL_W;

    logic [PROD-1:0] prod;
    logic [SHW-1:0]  top_idx;
    logic [SHW-1:0]  pos;
    logic            bit_val;

    // Low-slice product, zero-extended
    always_comb begin
        prod  = a_i[MUL_W-1:0] * b_i[MUL_W-1:0];
        mul_o = {{(W-PROD){1'b0}}, prod};
    end

    // Unsigned ordering results
    always_comb begin
        min_o = (a_i < b_i) ? a_i : b_i;
        max_o = (a_i < b_i) ? b_i : a_i;
        if (a_i > b_i)       cmp_o = W'(CMP_GT);
        else if (a_i == b_i) cmp_o = W'(CMP_EQ);
        else                 cmp_o = W'(CMP_LT);
    end

    // Highest set bit of B, zero when B is zero
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (b_i[i]) top_idx = SHW'(i);
        end
        msb_o = {{(W-SHW){1'b0}}, top_idx};
    end

    // Single-bit write: position in B[SHW:1], value in B[0]
    always_comb begin
        pos     = b_i[SHW:1];
        bit_val = b_i[0];
        setb_o  = (a_i & ~(W'(1) << pos)) | (W'(bit_val) << pos);
    end
endmodule

// File: rtl/cp_alu_carry.sv
// Module: the carry register. Loads next_i when we_i is high; clears on
// synchronous active-low reset; otherwise holds.
module cp_alu_carry #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] next_i,
    output logic [W-1:0] carry_o
);
    logic [W-1:0] carry_q;

    // Carry storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)     carry_q <= '0;
        else if (we_i)  carry_q <= next_i;
    end

    assign carry_o = carry_q;

    // R13
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(carry_q));
endmodule

// File: rtl/cp_alu.sv
// Module: top of the command-processor ALU. Selects operand B, routes the
// opcode to the result of the matching unit and decides carry writes.
// Assumes opcode decode and illegal-opcode handling live elsewhere.
module cp_alu #(
    parameter int W     = 32,
    parameter int MUL_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_i,
    input  logic [4:0]   opcode_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] imm_i,
    input  logic         use_imm_i,
    output logic [W-1:0] result_o
);
    import cp_alu_pkg::*;

    localparam int SHW = $clog2(W);

    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic [W-1:0] carry;
    logic         carry_we;
    logic [W-1:0] carry_next;

    logic [W-1:0] add_r, addc_r, sub_r, subc_r, add_c, sub_c;
    logic [W-1:0] and_r, or_r, xor_r, not_r, bic_r;
    logic [W-1:0] shl_r, shru_r, shrs_r, rotl_r;
    logic [W-1:0] mul_r, min_r, max_r, cmp_r, msb_r, setb_r;

    // Operand B source select and opcode typing
    always_comb begin
        op    = alu_op_e'(opcode_i);
        b_eff = use_imm_i ? imm_i : opb_i;
    end

    cp_alu_arith #(.W(W)) arith_i (
        .a_i(opa_i), .b_i(b_eff), .carry_i(carry),
        .add_o(add_r), .addc_o(addc_r), .sub_o(sub_r), .subc_o(subc_r),
        .add_carry_o(add_c), .sub_carry_o(sub_c)
    );

    cp_alu_bitops #(.W(W)) bitops_i (
        .a_i(opa_i), .b_i(b_eff),
        .and_o(and_r), .or_o(or_r), .xor_o(xor_r), .not_o(not_r),
        .bic_o(bic_r), .shl_o(shl_r), .shru_o(shru_r), .shrs_o(shrs_r),
        .rotl_o(rotl_r)
    );

    cp_alu_misc #(.W(W), .MUL_W(MUL_W)) misc_i (
        .a_i(opa_i), .b_i(b_eff),
        .mul_o(mul_r), .min_o(min_r), .max_o(max_r), .cmp_o(cmp_r),
        .msb_o(msb_r), .setb_o(setb_r)
    );

    // Carry write only for strobed low-word add or subtract
    always_comb begin
        carry_we   = exec_i && (op == OP_ADD || op == OP_SUB);
        carry_next = (op == OP_SUB) ? sub_c : add_c;
    end

    cp_alu_carry #(.W(W)) carry_i (
        .clk(clk), .rst_n(rst_n), .we_i(carry_we),
        .next_i(carry_next), .carry_o(carry)
    );

    // Result select by opcode; unassigned codes give zero
    always_comb begin
        unique case (op)
            OP_ADD:  result_o = add_r;
            OP_ADDC: result_o = addc_r;
            OP_SUB:  result_o = sub_r;
            OP_SUBC: result_o = subc_r;
            OP_AND:  result_o = and_r;
            OP_OR:   result_o = or_r;
            OP_XOR:  result_o = xor_r;
            OP_NOT:  result_o = not_r;
            OP_BIC:  result_o = bic_r;
            OP_SHL:  result_o = shl_r;
            OP_SHRU: result_o = shru_r;
            OP_SHRS: result_o = shrs_r;
            OP_ROTL: result_o = rotl_r;
            OP_MUL8: result_o = mul_r;
            OP_MIN:  result_o = min_r;
            OP_MAX:  result_o = max_r;
            OP_CMP:  result_o = cmp_r;
            OP_MSB:  result_o = msb_r;
            OP_SETB: result_o = setb_r;
            default: result_o = '0;
        endcase
    end

    // R2
    add_carry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op == OP_ADD) |=> (carry[W-1:1] == '0));

    // R3
    addc_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADDC) |=> $stable(carry));

    // R4
    sub_carry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op == OP_SUB) |=> (carry == '0 || carry == '1));

    // R8
    mul_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MUL8) |-> (result_o[W-1:2*MUL_W] == '0));

    // R10
    cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> (result_o == W'(CMP_GT) || result_o == W'(CMP_EQ)
                            || result_o == W'(CMP_LT)));

    // R11
    msb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MSB) |-> (result_o < W));

    // R12
    setb_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SETB) |-> (((result_o ^ opa_i) & ~(W'(1) << b_eff[SHW:1])) == '0));

    // R14
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i > 5'd18) |-> (result_o == '0));
endmodule

// File: tb/cp_alu_tb.sv
// Bench for cp_alu: vector table for stateless opcodes, then directed
// carry, reset and operand-select sequences.
module cp_alu_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec = 1'b0;
    logic [4:0]  opc = '0;
    logic [31:0] opa = '0, opb = '0, imm = '0;
    logic        use_imm = 1'b0;
    logic [31:0] res;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    cp_alu dut_i (
        .clk(clk), .rst_n(rst_n), .exec_i(exec), .opcode_i(opc),
        .opa_i(opa), .opb_i(opb), .imm_i(imm), .use_imm_i(use_imm),
        .result_o(res)
    );

    always #(CLK_P/2) clk = ~clk;

    // {opcode, A, B, expected}
    localparam logic [100:0] TBL [0:NV-1] = '{
        {5'd0,  32'h00000005, 32'h00000007, 32'h0000000C},
        {5'd0,  32'hFFFFFFFF, 32'h00000002, 32'h00000001},
        {5'd2,  32'h0000000A, 32'h00000003, 32'h00000007},
        {5'd2,  32'h00000003, 32'h00000005, 32'hFFFFFFFE},
        {5'd4,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},
        {5'd5,  32'h0F0F0000, 32'h000000FF, 32'h0F0F00FF},
        {5'd6,  32'hAAAA5555, 32'hFFFF0000, 32'h55555555},
        {5'd7,  32'h12345678, 32'h00000000, 32'hEDCBA987},
        {5'd8,  32'hFFFFFFFF, 32'h0F0F0F0F, 32'hF0F0F0F0},
        {5'd9,  32'h00000001, 32'h0000001F, 32'h80000000},
        {5'd9,  32'h00000003, 32'h00000021, 32'h00000006},
        {5'd10, 32'h80000000, 32'h00000004, 32'h08000000},
        {5'd11, 32'h80000000, 32'h00000004, 32'hF8000000},
        {5'd11, 32'h40000000, 32'h00000024, 32'h04000000},
        {5'd12, 32'h80000001, 32'h00000001, 32'h00000003},
        {5'd12, 32'h00000003, 32'hFFFFFFFF, 32'h80000001},
        {5'd12, 32'h12345678, 32'hFFFFFFFC, 32'h81234567},
        {5'd12, 32'h12345678, 32'h00000000, 32'h12345678},
        {5'd13, 32'h123456FF, 32'hABCDEFFF, 32'h0000FE01},
        {5'd13, 32'h00000010, 32'h00000020, 32'h00000200},
        {5'd14, 32'h00000005, 32'hFFFFFFFF, 32'h00000005},
        {5'd15, 32'h00000005, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {5'd14, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF},
        {5'd16, 32'h00000009, 32'h00000003, 32'h00000000},
        {5'd16, 32'h00000007, 32'h00000007, 32'h0000002B},
        {5'd16, 32'h00000003, 32'h00000009, 32'h0000001E},
        {5'd16, 32'h00000000, 32'hFFFFFFFF, 32'h0000001E},
        {5'd17, 32'h00000000, 32'h00000000, 32'h00000000},
        {5'd17, 32'h00000000, 32'h00000001, 32'h00000000},
        {5'd17, 32'h00000000, 32'h80000000, 32'h0000001F},
        {5'd17, 32'h00000000, 32'h00012345, 32'h00000010},
        {5'd18, 32'h00000000, 32'h0000000B, 32'h00000020},
        {5'd18, 32'hFFFFFFFF, 32'h0000003E, 32'h7FFFFFFF},
        {5'd18, 32'h0000000F, 32'h00000004, 32'h0000000B},
        {5'd18, 32'h0000000F, 32'h00000001, 32'h0000000F},
        {5'd31, 32'h00001234, 32'h00005678, 32'h00000000}
    };

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd0:                       return "R2";
            5'd2:                       return "R4";
            5'd4, 5'd5, 5'd6, 5'd7, 5'd8: return "R5";
            5'd9, 5'd10, 5'd11:         return "R6";
            5'd12:                      return "R7";
            5'd13:                      return "R8";
            5'd14, 5'd15:               return "R9";
            5'd16:                      return "R10";
            5'd17:                      return "R11";
            5'd18:                      return "R12";
            default:                    return "R14";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: result %h expected %h", req, got, exp);
        end
    endtask

    // Drive at the falling edge, then let the combinational result settle
    task automatic drive(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic ex);
        @(negedge clk);
        opc = o; opa = a; opb = b; exec = ex;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exec = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: carry is zero after reset
        drive(5'd1, 32'd1, 32'd2, 1'b0);
        check("R1", res, 32'd3);

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k][100:96], TBL[k][95:64], TBL[k][63:32], 1'b0);
            check(req_of(TBL[k][100:96]), res, TBL[k][31:0]);
        end

        // R2: overflowing add captures carry 1
        drive(5'd0, 32'hFFFFFFFF, 32'd1, 1'b1);
        check("R2", res, 32'd0);
        drive(5'd1, 32'd5, 32'd6, 1'b1);      // R3: consumes, keeps carry
        check("R3", res, 32'd12);
        drive(5'd1, 32'd0, 32'd0, 1'b0);
        check("R3", res, 32'd1);
        // R13: strobe low keeps carry across a non-overflowing add
        drive(5'd0, 32'd1, 32'd1, 1'b0);
        check("R13", res, 32'd2);
        drive(5'd4, 32'hFFFF, 32'h00FF, 1'b1); // R13: strobed non-carry op
        check("R5", res, 32'h00FF);
        drive(5'd1, 32'd0, 32'd0, 1'b0);
        check("R13", res, 32'd1);
        // R2: non-overflowing add clears carry
        drive(5'd0, 32'd1, 32'd1, 1'b1);
        drive(5'd1, 32'd0, 32'd0, 1'b0);
        check("R2", res, 32'd0);
        // R4: borrowing subtract loads all ones
        drive(5'd2, 32'd3, 32'd5, 1'b1);
        check("R4", res, 32'hFFFFFFFE);
        drive(5'd3, 32'd10, 32'd3, 1'b1);
        check("R4", res, 32'd6);
        drive(5'd3, 32'd0, 32'd0, 1'b0);
        check("R4", res, 32'hFFFFFFFF);
        drive(5'd2, 32'd5, 32'd3, 1'b1);
        drive(5'd3, 32'd10, 32'd3, 1'b0);
        check("R4", res, 32'd7);
        // R1: reset while carry set
        drive(5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        do_reset();
        drive(5'd1, 32'd0, 32'd0, 1'b0);
        check("R1", res, 32'd0);
        // R14: immediate replaces register operand B
        use_imm = 1'b1; imm = 32'h100;
        drive(5'd5, 32'd1, 32'd5, 1'b0);
        check("R14", res, 32'h101);
        drive(5'd16, 32'h100, 32'd5, 1'b0);
        check("R14", res, 32'h2B);
        use_imm = 1'b0;
        drive(5'd16, 32'h100, 32'd5, 1'b0);
        check("R14", res, 32'h00);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: result %h expected completion", res);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule